// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast input clock into the timing strobes of a serial transceiver. Software writes one divisor word that holds an unsigned fixed-point value: an integer mantissa plus a four-bit fraction in sixteenths. The block produces a one-cycle oversample strobe at sixteen times the bit rate. It also produces a bit strobe that marks every sixteenth oversample strobe.

A plain integer counter can only reach whole-cycle periods. This generator handles the fraction by lengthening some oversample periods in each group of sixteen by one input clock. The lengthened periods are spread evenly through the group. The average period is therefore the mantissa plus fraction/16 input clocks, and every group has the same exact length. A new divisor written while the generator runs is held back until the current group of sixteen ends, so no shortened or mixed period is produced. The generator runs only while its enable input is high. Software computes the divisor from the clock and baud rates before writing it.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both strobes are low and the active divisor is zero, so no strobe appears until a non-zero mantissa is written.
- R2: The divisor word carries the mantissa in bits [15:4] and the fraction in bits [3:0]. With a fraction of zero, `os_tick` is a one-cycle pulse that repeats every mantissa input clocks.
- R3: Sub-tick k of a group (k = 0..15, counted from the group start) lasts M + (floor((k+1)·F/16) − floor(k·F/16)) input clocks, where M is the mantissa and F is the fraction.
- R4: Each group of sixteen oversample strobes spans exactly 16·M + F input clocks.
- R5: `bit_tick` is high in the same cycle as the sixteenth `os_tick` of each group, and is never high at any other time.
- R6: While `enable` is low no strobe is produced, starting from the first clock edge at which it is low. When `enable` is raised the generator starts a fresh group at sub-tick 0. The first `os_tick` becomes visible after the P0-th rising edge at which `enable` is high, where P0 is the length of sub-tick 0.
- R7: While the active mantissa is zero no strobe is produced, even when `enable` is high.
- R8: While the generator runs, a divisor write takes effect at the end of the current group of sixteen. While it is idle (`enable` low or mantissa zero), the write takes effect at the next clock edge. When the write ends an idle state with `enable` high, the first `os_tick` appears P0+1 edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor word: mantissa [15:4], fraction [3:0] |
| enable | input | 1 | Generator run enable |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth oversample strobe |

## Verification
Assertions check several properties on every cycle. The period counter always stays below the length of the current sub-tick. Each completed group measures exactly the divisor word in input clocks. The active divisor never changes inside a running group. `bit_tick` only appears together with `os_tick`. A low `enable` or a zero mantissa silences both strobes. Only the bench scenarios can show where the lengthened periods fall within a group, the exact latency after enabling or after a write that ends an idle state, and that a write made mid-group leaves the remaining sub-ticks at the old length. The bench compares these against its own accumulator model of the fraction.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int FRAC_W  = 4;
  localparam int OS_RATE = 1 << FRAC_W;

  // One extra input clock for sub-tick k when the running sum k*F/16
  // crosses an integer boundary during that sub-tick.
  function automatic logic frac_extra(input logic [FRAC_W-1:0] f,
                                      input logic [FRAC_W-1:0] k);
    int unsigned hi;
    int unsigned lo;
    hi = ((int'(k) + 1) * int'(f)) >> FRAC_W;
    lo = (int'(k) * int'(f)) >> FRAC_W;
    return hi != lo;
  endfunction
endpackage

// File: rtl/fbg_div_reg.sv
module fbg_div_reg
  import fbg_pkg::*;
#(
  parameter int MANT_W = 12,
  localparam int DIV_W = MANT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic              load_now,
  output logic [MANT_W-1:0] act_mant,
  output logic [FRAC_W-1:0] act_frac
);
  logic [DIV_W-1:0] pend_q;
  logic [DIV_W-1:0] act_q;
  logic [DIV_W-1:0] pend_next;

  // Latest written word; a write in the load cycle is taken directly.
  assign pend_next = wr_en ? wr_data : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_next;
      if (load_now) act_q <= pend_next;
    end
  end

  assign act_mant = act_q[DIV_W-1:FRAC_W];
  assign act_frac = act_q[FRAC_W-1:0];
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt
  import fbg_pkg::*;
#(
  parameter int MANT_W = 12,
  localparam int CW = MANT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  output logic              sub_done,
  output logic              group_done,
  output logic              os_tick_q,
  output logic              bit_tick_q
);
  logic [CW-1:0]     cnt_q;
  logic [FRAC_W-1:0] sub_q;
  logic              extra;
  logic [CW-1:0]     period;

  assign extra      = frac_extra(frac, sub_q);
  assign period     = {1'b0, mant} + {{MANT_W{1'b0}}, extra};
  assign sub_done   = run && (cnt_q == period - CW'(1));
  assign group_done = sub_done && (sub_q == FRAC_W'(OS_RATE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sub_q      <= '0;
      os_tick_q  <= 1'b0;
      bit_tick_q <= 1'b0;
    end else begin
      os_tick_q  <= sub_done;
      bit_tick_q <= group_done;
      if (!run) begin
        cnt_q <= '0;
        sub_q <= '0;
      end else if (sub_done) begin
        cnt_q <= '0;
        sub_q <= sub_q + FRAC_W'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R3: the counter never runs past the current sub-tick length
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int MANT_W = 12,
  localparam int DIV_W = MANT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             enable,
  output logic             os_tick,
  output logic             bit_tick
);
  logic [MANT_W-1:0] act_mant;
  logic [FRAC_W-1:0] act_frac;
  logic              running;
  logic              sub_done;
  logic              group_done;
  logic              load_now;

  assign running  = enable && (act_mant != '0);
  assign load_now = !running || group_done;

  fbg_div_reg #(.MANT_W(MANT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (div_wr),
    .wr_data  (div_wdata),
    .load_now (load_now),
    .act_mant (act_mant),
    .act_frac (act_frac)
  );

  fbg_period_cnt #(.MANT_W(MANT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .mant       (act_mant),
    .frac       (act_frac),
    .sub_done   (sub_done),
    .group_done (group_done),
    .os_tick_q  (os_tick),
    .bit_tick_q (bit_tick)
  );

  // Group-length monitor for the R4 check.
  localparam int GW = DIV_W + 1;
  logic [GW-1:0] grp_cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       grp_cyc_q <= '0;
    else if (!running || group_done)  grp_cyc_q <= '0;
    else                              grp_cyc_q <= grp_cyc_q + GW'(1);
  end

  assert_group_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |-> (grp_cyc_q + GW'(1) == {1'b0, act_mant, act_frac}));

  assert_bit_with_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!os_tick && !bit_tick));

  assert_zero_mant_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mant == '0) |=> !os_tick);

  assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !group_done) |=> $stable({act_mant, act_frac}));
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        enable = 1'b0;
  logic        os_tick;
  logic        bit_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .enable(enable), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Accumulator view of the fraction: a carry out of the 4-bit sum adds a cycle.
  function automatic int model_period(input int m, input int f, input int k);
    int acc = 0;
    int ext = 0;
    for (int i = 0; i <= k; i++) begin
      acc += f;
      ext = (acc >= 16) ? 1 : 0;
      if (ext == 1) acc -= 16;
    end
    return m + ext;
  endfunction

  task automatic wait_tick(output int n, output bit b);
    n = 0;
    do begin
      @(negedge clk);
      div_wr = 1'b0;
      n++;
    end while (!os_tick && n < 5000);
    b = bit_tick;
  endtask

  task automatic idle_check(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      div_wr = 1'b0;
      chk(!os_tick && !bit_tick, req, int'(os_tick) + int'(bit_tick), 0);
    end
  endtask

  task automatic write_div(input int m, input int f);
    div_wr    = 1'b1;
    div_wdata = {m[11:0], f[3:0]};
  endtask

  task automatic run_group(input int m, input int f, input int k_from, input int k_to,
                           input int first_add, input string req);
    int n;
    bit b;
    int sum = 0;
    for (int k = k_from; k <= k_to; k++) begin
      int exp;
      wait_tick(n, b);
      exp = model_period(m, f, k) + ((k == k_from) ? first_add : 0);
      chk(n == exp, req, n, exp);
      chk(b == (k == 15), "R5", int'(b), int'(k == 15));
      sum += n;
    end
    if (k_from == 0 && k_to == 15 && first_add == 0)
      chk(sum == 16 * m + f, "R4", sum, 16 * m + f);
  endtask

  task automatic start_with(input int m, input int f);
    enable = 1'b0;
    @(negedge clk);
    write_div(m, f);
    idle_check(2, "R6");
    enable = 1'b1;
  endtask

  task automatic t_reset();
    chk(!os_tick && !bit_tick, "R1", int'(os_tick) + int'(bit_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    idle_check(30, "R1");
  endtask

  task automatic t_integer();
    start_with(3, 0);
    run_group(3, 0, 0, 15, 0, "R2");
    run_group(3, 0, 0, 15, 0, "R2");
  endtask

  task automatic t_fraction();
    start_with(5, 7);
    run_group(5, 7, 0, 15, 0, "R3");
    run_group(5, 7, 0, 15, 0, "R3");
    start_with(1, 15);
    run_group(1, 15, 0, 15, 0, "R3");
    start_with(2, 1);
    run_group(2, 1, 0, 15, 0, "R3");
  endtask

  task automatic t_zero_mant();
    start_with(0, 9);
    idle_check(40, "R7");
    write_div(6, 3);
    run_group(6, 3, 0, 15, 1, "R8");
  endtask

  task automatic t_rewrite();
    start_with(4, 0);
    run_group(4, 0, 0, 4, 0, "R8");
    write_div(7, 0);
    run_group(4, 0, 5, 15, 0, "R8");
    run_group(7, 0, 0, 15, 0, "R8");
  endtask

  task automatic t_enable();
    start_with(7, 0);
    run_group(7, 0, 0, 2, 0, "R6");
    @(negedge clk);
    enable = 1'b0;
    idle_check(20, "R6");
    enable = 1'b1;
    run_group(7, 0, 0, 15, 0, "R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_integer();
    t_fraction();
    t_zero_mant();
    t_rewrite();
    t_enable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule